// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges up to five reset requests into a single active-high system reset and keeps a record of which sources caused the latest reset. The requests are an active-low external reset pin, a clock-loss timeout from a missing-clock monitor, the output of an analog comparator (seen here as a digital level), an active-low conversion-start pin, and a watchdog overflow pulse. The comparator and the conversion-start pin only take part once software has enabled them. The clock-loss timeout only counts while its monitor enable input is high.

Software enables the comparator and conversion-start sources by writing 1 to their bits in an 8-bit configuration write. Those same bit positions later read back as cause flags. Every reset, including the one at power-on, is held for a fixed number of clock cycles after the last request goes away. The comparator path asserts the reset at once, with no clock edge needed, and is released through a two-stage synchronizer. The internal sources do not drive the external pin.

Top module: `rst_ctrl`

## Requirements
- R1: The external pin (`ext_rst_ni`) passes through a two-stage synchronizer, so `sys_rst_o` rises on the third rising edge after the pin goes low. After the pin returns high, `sys_rst_o` stays high up to and including the 14th rising edge and falls on the 15th (default `HOLD`=12).
- R2: Bit 0 of `src_o` reads 1 after a reset caused by the external pin.
- R3: When `clk_mon_en_i` and `clk_lost_i` are both high at a rising edge, `sys_rst_o` is high after that edge and bit 2 of `src_o` is set. `clk_lost_i` is ignored while `clk_mon_en_i` is low.
- R4: Once bit 5 has been written as 1, a low level on `cmp_i` resets the system, and bit 5 of `src_o` reads 1 afterwards.
- R5: With the comparator enabled, `cmp_i` going low drives `sys_rst_o` high even while no clock edges occur.
- R6: Once bit 6 has been written as 1, a low level on `cnv_ni` resets the system after two-stage synchronization, and bit 6 of `src_o` reads 1 afterwards.
- R7: A high `wdt_ovf_i` at a rising edge resets the system and sets bit 3 of `src_o`.
- R8: When several sources are active in the entry cycle, all of their flags are set. Flags of sources that are not active in the entry cycle are cleared. Sources that become active while reset is held add their flags. `src_o` changes only while `sys_rst_o` is high. Bits 1, 4 and 7 always read 0.
- R9: The two enable bits survive resets from the clock-loss, watchdog, comparator and conversion-start sources. A reset from the external pin clears them.
- R10: A configuration write takes effect only when `sys_rst_o` is low. Bits 5 and 6 of `src_o` show cause, not enable: writing 1 leaves them at 0.
- R11: `sys_rst_o` is high from `rst_ni` low until the 13th rising edge after `rst_ni` rises. After any internal request ends, `sys_rst_o` stays high for 12 more rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External reset pin, active low |
| clk_lost_i | input | 1 | Clock-loss timeout from the missing-clock monitor |
| clk_mon_en_i | input | 1 | Enables the clock-loss source |
| cmp_i | input | 1 | Comparator output; low means the non-inverting input is below the inverting input |
| cnv_ni | input | 1 | Conversion-start pin, active low |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data; bit 5 enables the comparator, bit 6 enables conversion-start |
| sys_rst_o | output | 1 | System reset, active high |
| src_o | output | 8 | Reset cause flags: bit 0 pin, bit 2 clock loss, bit 3 watchdog, bit 5 comparator, bit 6 conversion-start |

## Verification
Two kinds of same-cycle events are provoked on purpose. First, two sources rise in the same cycle: clock loss and watchdog fire together, and the record must hold both flags with the older flags cleared. Second, a configuration write lands while reset is held; the write must be dropped, which is judged later when the conversion-start pin still causes a reset. A behavioural model in the bench predicts `sys_rst_o` and `src_o` on every cycle. Separate checks target the edge-exact release timing and the comparator assertion while the clock is stopped.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;
  localparam int unsigned SRC_W = 8;
  localparam int unsigned B_PIN = 0;
  localparam int unsigned B_MCD = 2;
  localparam int unsigned B_WDT = 3;
  localparam int unsigned B_CMP = 5;
  localparam int unsigned B_CNV = 6;
  localparam logic [SRC_W-1:0] SRC_MASK =
    SRC_W'((1 << B_PIN) | (1 << B_MCD) | (1 << B_WDT) | (1 << B_CMP) | (1 << B_CNV));
endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rst_async_path.sv
// Asserts at once on hit_i, releases STAGES edges after hit_i drops.
module rst_async_path #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic act_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni or posedge hit_i) begin
    if (!rst_ni)    sr_q <= '0;
    else if (hit_i) sr_q <= '1;
    else            sr_q <= {sr_q[STAGES-2:0], 1'b0};
  end

  assign act_o = sr_q[STAGES-1];
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int unsigned HOLD = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_i,
  output logic rst_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;
  logic          rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CW'(HOLD);
      rst_q <= 1'b1;
    end else begin
      rst_q <= any_i || (cnt_q != '0);
      if (any_i)              cnt_q <= CW'(HOLD);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rst_o = rst_q;
endmodule

// File: rtl/rst_src_reg.sv
module rst_src_reg
  import rst_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] req_i,
  input  logic             in_rst_i,
  input  logic             wr_block_i,
  input  logic             clr_en_i,
  input  logic             we_i,
  input  logic             wr_cmp_i,
  input  logic             wr_cnv_i,
  output logic [SRC_W-1:0] flags_o,
  output logic             en_cmp_o,
  output logic             en_cnv_o
);
  logic any_req;
  assign any_req = |req_i;

  for (genvar i = 0; i < SRC_W; i++) begin : g_flag
    if (SRC_MASK[i]) begin : g_live
      logic f_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       f_q <= 1'b0;
        else if (in_rst_i) f_q <= f_q | req_i[i];
        else if (any_req)  f_q <= req_i[i];
      end
      assign flags_o[i] = f_q;
    end else begin : g_zero
      assign flags_o[i] = 1'b0;
    end
  end

  logic en_cmp_q, en_cnv_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_cmp_q <= 1'b0;
      en_cnv_q <= 1'b0;
    end else if (clr_en_i) begin
      en_cmp_q <= 1'b0;
      en_cnv_q <= 1'b0;
    end else if (we_i && !wr_block_i) begin
      en_cmp_q <= wr_cmp_i;
      en_cnv_q <= wr_cnv_i;
    end
  end

  assign en_cmp_o = en_cmp_q;
  assign en_cnv_o = en_cnv_q;
endmodule

// File: rtl/rst_ctrl.sv
module rst_ctrl
  import rst_ctrl_pkg::*;
#(
  parameter int unsigned HOLD      = 12,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_rst_ni,
  input  logic             clk_lost_i,
  input  logic             clk_mon_en_i,
  input  logic             cmp_i,
  input  logic             cnv_ni,
  input  logic             wdt_ovf_i,
  input  logic             cfg_we_i,
  input  logic [SRC_W-1:0] cfg_wdata_i,
  output logic             sys_rst_o,
  output logic [SRC_W-1:0] src_o
);
  logic ext_s, cnv_s, cmp_act, cmp_hit, rst_q;
  logic en_cmp_w, en_cnv_w;
  logic [SRC_W-1:0] req;
  logic unused_wdata;

  assign unused_wdata = ^cfg_wdata_i;

  rst_sync2 #(.STAGES(SYNC_STGS), .RST_VAL(1'b1)) u_ext_sync (
    .clk_i, .rst_ni, .d_i(ext_rst_ni), .q_o(ext_s)
  );

  rst_sync2 #(.STAGES(SYNC_STGS), .RST_VAL(1'b1)) u_cnv_sync (
    .clk_i, .rst_ni, .d_i(cnv_ni), .q_o(cnv_s)
  );

  assign cmp_hit = en_cmp_w & ~cmp_i;

  rst_async_path #(.STAGES(SYNC_STGS)) u_cmp_path (
    .clk_i, .rst_ni, .hit_i(cmp_hit), .act_o(cmp_act)
  );

  always_comb begin
    req        = '0;
    req[B_PIN] = ~ext_s;
    req[B_MCD] = clk_mon_en_i & clk_lost_i;
    req[B_WDT] = wdt_ovf_i;
    req[B_CMP] = cmp_act;
    req[B_CNV] = en_cnv_w & ~cnv_s;
  end

  rst_stretch #(.HOLD(HOLD)) u_stretch (
    .clk_i, .rst_ni, .any_i(|req), .rst_o(rst_q)
  );

  // comparator path bypasses the register so it works without a clock
  assign sys_rst_o = rst_q | cmp_act;

  rst_src_reg u_src (
    .clk_i, .rst_ni,
    .req_i      (req),
    .in_rst_i   (rst_q),
    .wr_block_i (sys_rst_o),
    .clr_en_i   (req[B_PIN]),
    .we_i       (cfg_we_i),
    .wr_cmp_i   (cfg_wdata_i[B_CMP]),
    .wr_cnv_i   (cfg_wdata_i[B_CNV]),
    .flags_o    (src_o),
    .en_cmp_o   (en_cmp_w),
    .en_cnv_o   (en_cnv_w)
  );
endmodule

// File: rtl/rst_ctrl_chk.sv
module rst_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ext_rst_ni,
  input logic       cmp_i,
  input logic       cfg_we_i,
  input logic       sys_rst_o,
  input logic [7:0] src_o,
  input logic       en_cmp,
  input logic       en_cnv
);
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  a_r1_pin_enters: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && !ext_rst_ni && $past(!ext_rst_ni)) |=> ##1 sys_rst_o);

  a_r5_cmp_immediate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_cmp && !cmp_i) |-> sys_rst_o);

  a_r9_pin_clears_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && !ext_rst_ni && $past(!ext_rst_ni)) |=> ##1 (!en_cmp && !en_cnv));

  a_r10_write_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_o && cfg_we_i) |=> (en_cnv == $past(en_cnv) || !en_cnv));

  a_r8_flags_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_o |-> $stable(src_o));
endmodule

bind rst_ctrl rst_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ext_rst_ni (ext_rst_ni),
  .cmp_i      (cmp_i),
  .cfg_we_i   (cfg_we_i),
  .sys_rst_o  (sys_rst_o),
  .src_o      (src_o),
  .en_cmp     (en_cmp_w),
  .en_cnv     (en_cnv_w)
);

// File: tb/sim_rst_ctrl.sv
module sim_rst_ctrl;
  logic clk_i = 1'b0;
  logic clk_run = 1'b1;
  logic rst_ni = 1'b0;
  logic ext_rst_ni = 1'b1, clk_lost_i = 1'b0, clk_mon_en_i = 1'b0;
  logic cmp_i = 1'b1, cnv_ni = 1'b1, wdt_ovf_i = 1'b0, cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = 8'h00;
  logic sys_rst_o;
  logic [7:0] src_o;

  int total = 0, bad = 0, ncyc = 0;
  string cur = "R11";

  always begin
    #10;
    if (clk_run) clk_i = ~clk_i;
  end

  rst_ctrl u0 (.*);

  // behavioural reference model
  bit m_e1 = 1, m_e2 = 1, m_c1s = 1, m_c2s = 1, m_k1 = 0, m_k2 = 0;
  bit m_rstq = 1, m_en_cmp = 0, m_en_cnv = 0;
  int m_cnt = 12;
  bit [7:0] m_flags = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_e1 = 1; m_e2 = 1; m_c1s = 1; m_c2s = 1; m_k1 = 0; m_k2 = 0;
      m_rstq = 1; m_en_cmp = 0; m_en_cnv = 0; m_cnt = 12; m_flags = 0;
    end else begin
      bit hit, k1, k2, anyr, pre_sys;
      bit [7:0] rq;
      hit = m_en_cmp && !cmp_i;
      k1 = m_k1 || hit;
      k2 = m_k2 || hit;
      rq = 0;
      rq[0] = !m_e2;
      rq[2] = clk_mon_en_i && clk_lost_i;
      rq[3] = wdt_ovf_i;
      rq[5] = k2;
      rq[6] = m_en_cnv && !m_c2s;
      anyr = |rq;
      pre_sys = m_rstq || k2;
      if (rq[0]) begin m_en_cmp = 0; m_en_cnv = 0; end
      else if (cfg_we_i && !pre_sys) begin
        m_en_cmp = cfg_wdata_i[5]; m_en_cnv = cfg_wdata_i[6];
      end
      if (m_rstq) m_flags = m_flags | rq;
      else if (anyr) m_flags = rq;
      m_rstq = anyr || (m_cnt != 0);
      if (anyr) m_cnt = 12; else if (m_cnt != 0) m_cnt = m_cnt - 1;
      m_e2 = m_e1; m_e1 = ext_rst_ni;
      m_c2s = m_c1s; m_c1s = cnv_ni;
      m_k2 = hit ? 1'b1 : k1;
      m_k1 = hit;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      ncyc++;
      chk({cur, " model sys_rst"}, int'(sys_rst_o),
          int'(m_rstq || m_k2 || (m_en_cmp && !cmp_i)));
      chk({cur, " model src"}, int'(src_o), int'(m_flags));
    end
  endtask

  initial begin
    fork
      begin
        cyc(3);
        chk("R11 reset state sys", int'(sys_rst_o), 1);
        chk("R11 reset state src", int'(src_o), 0);
        rst_ni = 1'b1;
        cyc(12);
        chk("R11 por hold", int'(sys_rst_o), 1);
        cyc(1);
        chk("R11 por release", int'(sys_rst_o), 0);
        cyc(5);

        cur = "R1";
        ext_rst_ni = 1'b0;
        cyc(2);
        chk("R1 sync delay", int'(sys_rst_o), 0);
        cyc(1);
        chk("R1 pin asserts", int'(sys_rst_o), 1);
        cyc(5);
        ext_rst_ni = 1'b1;
        cyc(14);
        chk("R1 stretch held", int'(sys_rst_o), 1);
        cyc(1);
        chk("R1 stretch released", int'(sys_rst_o), 0);
        chk("R2 pin flag", int'(src_o), 8'h01);

        cur = "R10";
        cfg_we_i = 1'b1; cfg_wdata_i = 8'h60;
        cyc(1);
        cfg_we_i = 1'b0; cfg_wdata_i = 8'h00;
        cyc(3);
        chk("R10 enable not shown as cause", int'(src_o), 8'h01);

        cur = "R3";
        clk_lost_i = 1'b1;
        cyc(1);
        clk_lost_i = 1'b0;
        cyc(3);
        chk("R3 ignored when disabled", int'(sys_rst_o), 0);
        clk_mon_en_i = 1'b1; clk_lost_i = 1'b1;
        cyc(1);
        chk("R3 clock loss reset", int'(sys_rst_o), 1);
        chk("R8 entry clears pin flag", int'(src_o), 8'h04);
        clk_lost_i = 1'b0;
        cyc(12);
        chk("R11 internal stretch held", int'(sys_rst_o), 1);
        cyc(1);
        chk("R11 internal stretch released", int'(sys_rst_o), 0);

        cur = "R7";
        wdt_ovf_i = 1'b1;
        cyc(1);
        wdt_ovf_i = 1'b0;
        cyc(20);
        chk("R7 watchdog flag", int'(src_o), 8'h08);

        cur = "R6";
        cnv_ni = 1'b0;
        cyc(4);
        chk("R9 cnv enable survived", int'(sys_rst_o), 1);
        cnv_ni = 1'b1;
        cyc(25);
        chk("R6 cnv flag", int'(src_o), 8'h40);

        cur = "R5";
        clk_run = 1'b0;
        cmp_i = 1'b0;
        #45;
        chk("R5 comparator without clock", int'(sys_rst_o), 1);
        clk_run = 1'b1;
        cur = "R4";
        cyc(3);
        cmp_i = 1'b1;
        cyc(25);
        chk("R4 comparator flag", int'(src_o), 8'h20);
        chk("R4 released", int'(sys_rst_o), 0);

        cur = "R8";
        clk_lost_i = 1'b1; wdt_ovf_i = 1'b1;
        cyc(1);
        clk_lost_i = 1'b0; wdt_ovf_i = 1'b0;
        chk("R8 simultaneous flags", int'(src_o), 8'h0C);
        cyc(20);

        cur = "R10";
        wdt_ovf_i = 1'b1;
        cyc(1);
        wdt_ovf_i = 1'b0;
        cfg_we_i = 1'b1; cfg_wdata_i = 8'h00;
        cyc(1);
        cfg_we_i = 1'b0;
        cyc(20);
        cnv_ni = 1'b0;
        cyc(4);
        chk("R10 write during reset dropped", int'(sys_rst_o), 1);
        cnv_ni = 1'b1;
        cyc(20);
        chk("R6 cnv flag again", int'(src_o), 8'h40);

        cur = "R9";
        ext_rst_ni = 1'b0;
        cyc(4);
        ext_rst_ni = 1'b1;
        cyc(20);
        cnv_ni = 1'b0;
        cyc(5);
        chk("R9 cnv enable cleared by pin", int'(sys_rst_o), 0);
        cnv_ni = 1'b1;
        cmp_i = 1'b0;
        cyc(3);
        chk("R9 cmp enable cleared by pin", int'(sys_rst_o), 0);
        chk("R2 pin flag kept", int'(src_o), 8'h01);
        cmp_i = 1'b1;
        cyc(2);
      end
      begin
        while (ncyc < 5000) #20;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule